// File: doc/BRIEF.md
# Memory Window Chip-Select Decoder

This block turns a 16-bit bus address into active-low chip selects and write strobes for three byte-wide memory sockets. A two-bit window mode sets the memory size: 8K, 16K or 32K per device. The mode picks which high address lines feed an eight-way one-hot decode, and forces the lines it does not use high. A fixed routing, which differs from mode to mode, connects one decode output to each socket.

A single enable gates the whole decode. It is active only when all of these hold: the bus marks the address valid, the external disable input is released, and the power-fail reset is released. An optional notch clears the enable across a 2K peripheral register window at B000-B7FF, so that no on-board memory answers there. Each socket has a write-protect option. When it is set, that socket's write strobe stays inactive and the RAM behaves as read-only. All outputs are combinational.

Top module: `memsel_decoder`

## Requirements
- R1: `win_mode` selects the window size: 2'b00 is 8K (decode index = addr[15:13]), 2'b01 is 16K (index = {addr[15:14],1}) and 2'b10 is 32K (index = {addr[15],1,1}).
- R2: Socket 0 (`sock_cs_n[0]`) is selected for 0000-1FFF in 8K mode, 0000-3FFF in 16K mode and 0000-7FFF in 32K mode.
- R3: Socket 1 (`sock_cs_n[1]`) is selected for C000-DFFF in 8K mode and 8000-BFFF in 16K mode, and is never selected in 32K mode.
- R4: Socket 2 (`sock_cs_n[2]`) is selected for E000-FFFF in 8K mode, C000-FFFF in 16K mode and 8000-FFFF in 32K mode.
- R5: At most one bit of `sock_cs_n` is low at any time. Every address outside the ranges in R2-R4 leaves all three bits high.
- R6: No select is low while `addr_vld` is 0 or while `ext_dis_n` is 0.
- R7: While `pf_rst_n` is 0, all selects and all write strobes are high, whatever the other inputs are.
- R8: While `notch_en` is 1, any address with addr[15:11] = 5'b10110 (B000-B7FF) leaves all selects high. While `notch_en` is 0, that range decodes normally.
- R9: `sock_we_n[s]` is low exactly when `sock_cs_n[s]` is low, `bus_e` is 1, `rd_wr_n` is 0 (write) and `wr_prot[s]` is 0.
- R10: While `wr_prot[s]` is 1, `sock_we_n[s]` stays high and `sock_cs_n[s]` still follows R2-R4.
- R11: Mode encoding 2'b11 decodes exactly as 32K mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Bus address |
| bus_e | input | 1 | Bus clock phase; writes are strobed while it is high |
| addr_vld | input | 1 | Address-valid strobe, active high |
| ext_dis_n | input | 1 | External on-board disable, active low |
| pf_rst_n | input | 1 | Power-fail reset, active low |
| win_mode | input | 2 | Window size: 00 8K, 01 16K, 10/11 32K |
| notch_en | input | 1 | Enables the B000-B7FF decode hole |
| rd_wr_n | input | 1 | 1 = read cycle, 0 = write cycle |
| wr_prot | input | 3 | Per-socket write protect |
| sock_cs_n | output | 3 | Per-socket chip select, active low |
| sock_we_n | output | 3 | Per-socket write strobe, active low |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle as the address that exposes it. A wrong index line, a wrong routing entry or a wrong gate term shows up as a select asserted in the wrong range, as two selects asserted together, or as a missing select. The bench sweeps the address space in every mode, with and without the notch, and compares each result against a range table. A slip at a window boundary therefore surfaces on the first address across that boundary.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

   typedef enum logic [1:0] {
      WIN_8K     = 2'b00,
      WIN_16K    = 2'b01,
      WIN_32K    = 2'b10,
      WIN_32K_B  = 2'b11
   } win_mode_e;

   typedef struct packed {
      logic       used;
      logic [2:0] idx;
   } route_t;

   // How many low index lines are forced high for a given mode.
   function automatic logic [1:0] forced_lines(win_mode_e m);
      case (m)
         WIN_8K:  return 2'd0;
         WIN_16K: return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   // Which decode output reaches socket s in mode m.
   function automatic route_t route_of(int unsigned s, win_mode_e m);
      route_t r;
      r.used = 1'b1;
      r.idx  = 3'd7;
      case (s)
         0: begin
            case (m)
               WIN_8K:  r.idx = 3'd0;
               WIN_16K: r.idx = 3'd1;
               default: r.idx = 3'd3;
            endcase
         end
         1: begin
            case (m)
               WIN_8K:  r.idx = 3'd6;
               WIN_16K: r.idx = 3'd5;
               default: begin
                  r.used = 1'b0;
                  r.idx  = 3'd0;
               end
            endcase
         end
         default: r.idx = 3'd7;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/memsel_index.sv
module memsel_index
   import memsel_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] hi_addr,
   input  win_mode_e        mode,
   output logic [IDX_W-1:0] idx
);

   logic [1:0] n_forced;

   always_comb n_forced = forced_lines(mode);

   for (genvar j = 0; j < IDX_W; j++) begin : g_bit
      assign idx[j] = (int'(n_forced) <= j) ? hi_addr[j] : 1'b1;
   end

endmodule

// File: rtl/memsel_onehot.sv
module memsel_onehot #(
   parameter int IDX_W = 3,
   localparam int N_OUT = 1 << IDX_W
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             en,
   output logic [N_OUT-1:0] dec_n
);

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      localparam logic [IDX_W-1:0] KV = IDX_W'(k);
      assign dec_n[k] = ~(en && (idx == KV));
   end

endmodule

// File: rtl/memsel_gate.sv
module memsel_gate #(
   parameter int              NOTCH_W       = 5,
   parameter logic [NOTCH_W-1:0] NOTCH_TAG  = 5'b10110,
   parameter bit              NOTCH_PRESENT = 1'b1
) (
   input  logic [NOTCH_W-1:0] tag_addr,
   input  logic               addr_vld,
   input  logic               ext_dis_n,
   input  logic               pf_rst_n,
   input  logic               notch_en,
   output logic               en
);

   logic in_notch;

   if (NOTCH_PRESENT) begin : g_notch
      assign in_notch = notch_en && (tag_addr == NOTCH_TAG);
   end else begin : g_no_notch
      logic notch_unused;
      assign notch_unused = notch_en ^ (^tag_addr);
      assign in_notch     = 1'b0;
   end

   // Reset and notch share the external-disable path.
   logic dis_path_n;
   assign dis_path_n = ext_dis_n && pf_rst_n && !in_notch;
   assign en         = addr_vld && dis_path_n;

endmodule

// File: rtl/memsel_route.sv
module memsel_route
   import memsel_pkg::*;
#(
   parameter int N_OUT  = 8,
   parameter int N_SOCK = 3
) (
   input  logic [N_OUT-1:0]  dec_n,
   input  win_mode_e         mode,
   output logic [N_SOCK-1:0] cs_n
);

   for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
      route_t r;
      always_comb r = route_of(s, mode);
      assign cs_n[s] = r.used ? dec_n[r.idx] : 1'b1;
   end

endmodule

// File: rtl/memsel_wstrobe.sv
module memsel_wstrobe #(
   parameter int N_SOCK = 3
) (
   input  logic [N_SOCK-1:0] cs_n,
   input  logic              bus_e,
   input  logic              rd_wr_n,
   input  logic [N_SOCK-1:0] wr_prot,
   output logic [N_SOCK-1:0] we_n
);

   for (genvar s = 0; s < N_SOCK; s++) begin : g_we
      assign we_n[s] = ~(!cs_n[s] && bus_e && !rd_wr_n && !wr_prot[s]);
   end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
   import memsel_pkg::*;
#(
   parameter int                 ADDR_W        = 16,
   parameter int                 IDX_W         = 3,
   parameter int                 N_SOCK        = 3,
   parameter int                 NOTCH_W       = 5,
   parameter logic [NOTCH_W-1:0] NOTCH_TAG     = 5'b10110,
   parameter bit                 NOTCH_PRESENT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              bus_e,
   input  logic              addr_vld,
   input  logic              ext_dis_n,
   input  logic              pf_rst_n,
   input  logic [1:0]        win_mode,
   input  logic              notch_en,
   input  logic              rd_wr_n,
   input  logic [N_SOCK-1:0] wr_prot,
   output logic [N_SOCK-1:0] sock_cs_n,
   output logic [N_SOCK-1:0] sock_we_n
);

   localparam int N_OUT  = 1 << IDX_W;
   localparam int LOW_W  = ADDR_W - NOTCH_W;

   if (IDX_W != 3) begin : g_bad_idx
      $error("memsel_decoder: routing table assumes an eight-way decode");
   end
   if (N_SOCK != 3) begin : g_bad_sock
      $error("memsel_decoder: routing table covers three sockets");
   end
   if (NOTCH_W < IDX_W || LOW_W < 1) begin : g_bad_notch
      $error("memsel_decoder: notch width must lie between index width and address width");
   end

   win_mode_e             mode;
   logic [IDX_W-1:0]      idx;
   logic                  en;
   logic [N_OUT-1:0]      dec_n;
   logic                  addr_lo_unused;

   assign mode           = win_mode_e'(win_mode);
   assign addr_lo_unused = ^addr[LOW_W-1:0];

   memsel_index #(.IDX_W(IDX_W)) index_i (
      .hi_addr (addr[ADDR_W-1 -: IDX_W]),
      .mode    (mode),
      .idx     (idx)
   );

   memsel_gate #(
      .NOTCH_W       (NOTCH_W),
      .NOTCH_TAG     (NOTCH_TAG),
      .NOTCH_PRESENT (NOTCH_PRESENT)
   ) gate_i (
      .tag_addr  (addr[ADDR_W-1 -: NOTCH_W]),
      .addr_vld  (addr_vld),
      .ext_dis_n (ext_dis_n),
      .pf_rst_n  (pf_rst_n),
      .notch_en  (notch_en),
      .en        (en)
   );

   memsel_onehot #(.IDX_W(IDX_W)) onehot_i (
      .idx   (idx),
      .en    (en),
      .dec_n (dec_n)
   );

   memsel_route #(.N_OUT(N_OUT), .N_SOCK(N_SOCK)) route_i (
      .dec_n (dec_n),
      .mode  (mode),
      .cs_n  (sock_cs_n)
   );

   memsel_wstrobe #(.N_SOCK(N_SOCK)) wstrobe_i (
      .cs_n    (sock_cs_n),
      .bus_e   (bus_e),
      .rd_wr_n (rd_wr_n),
      .wr_prot (wr_prot),
      .we_n    (sock_we_n)
   );

endmodule

// File: rtl/memsel_checker.sv
module memsel_checker #(
   parameter int                 ADDR_W    = 16,
   parameter int                 N_SOCK    = 3,
   parameter int                 NOTCH_W   = 5,
   parameter logic [NOTCH_W-1:0] NOTCH_TAG = 5'b10110
) (
   input logic [ADDR_W-1:0] addr,
   input logic              bus_e,
   input logic              addr_vld,
   input logic              ext_dis_n,
   input logic              pf_rst_n,
   input logic [1:0]        win_mode,
   input logic              notch_en,
   input logic              rd_wr_n,
   input logic [N_SOCK-1:0] wr_prot,
   input logic [N_SOCK-1:0] sock_cs_n,
   input logic [N_SOCK-1:0] sock_we_n
);

   AST_ONE_SELECT: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      $onehot0(~sock_cs_n)); // R5

   AST_NEED_STROBE: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      (!addr_vld || !ext_dis_n) |-> (&sock_cs_n)); // R6

   always @(posedge bus_e) begin
      if (!pf_rst_n) begin
         AST_PFAIL_QUIET: assert ((&sock_cs_n) && (&sock_we_n)); // R7
      end
   end

   AST_NOTCH_HOLE: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      (notch_en && addr[ADDR_W-1 -: NOTCH_W] == NOTCH_TAG) |-> (&sock_cs_n)); // R8

   AST_WE_NEEDS_CS: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      ((~sock_we_n) & sock_cs_n) == '0); // R9

   AST_WE_WRITE_ONLY: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      rd_wr_n |-> (&sock_we_n)); // R9

   AST_PROT_NO_WE: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      ((~sock_we_n) & wr_prot) == '0); // R10

   AST_SOCK1_WIDE_OFF: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      win_mode[1] |-> sock_cs_n[1]); // R3

   AST_SOCK0_LOW_HALF: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      !sock_cs_n[0] |-> !addr[ADDR_W-1]); // R2

   AST_SOCK2_HIGH_HALF: assert property (@(posedge bus_e) disable iff (!pf_rst_n)
      !sock_cs_n[2] |-> addr[ADDR_W-1]); // R4

endmodule

bind memsel_decoder memsel_checker #(
   .ADDR_W    (ADDR_W),
   .N_SOCK    (N_SOCK),
   .NOTCH_W   (NOTCH_W),
   .NOTCH_TAG (NOTCH_TAG)
) chk_i (
   .addr      (addr),
   .bus_e     (bus_e),
   .addr_vld  (addr_vld),
   .ext_dis_n (ext_dis_n),
   .pf_rst_n  (pf_rst_n),
   .win_mode  (win_mode),
   .notch_en  (notch_en),
   .rd_wr_n   (rd_wr_n),
   .wr_prot   (wr_prot),
   .sock_cs_n (sock_cs_n),
   .sock_we_n (sock_we_n)
);

// File: tb/memsel_decoder_tb_top.sv
`timescale 1ns/1ps
module memsel_decoder_tb_top;

   localparam int CLK_P = 10;

   logic [15:0] addr;
   logic        bus_e;
   logic        addr_vld;
   logic        ext_dis_n;
   logic        pf_rst_n;
   logic [1:0]  win_mode;
   logic        notch_en;
   logic        rd_wr_n;
   logic [2:0]  wr_prot;
   logic [2:0]  sock_cs_n;
   logic [2:0]  sock_we_n;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 0;

   memsel_decoder dut_i (
      .addr      (addr),
      .bus_e     (bus_e),
      .addr_vld  (addr_vld),
      .ext_dis_n (ext_dis_n),
      .pf_rst_n  (pf_rst_n),
      .win_mode  (win_mode),
      .notch_en  (notch_en),
      .rd_wr_n   (rd_wr_n),
      .wr_prot   (wr_prot),
      .sock_cs_n (sock_cs_n),
      .sock_we_n (sock_we_n)
   );

   initial begin
      bus_e = 1'b0;
      forever #(CLK_P/2) bus_e = ~bus_e;
   end

   // Range table taken from the requirements: returns active-high select set.
   function automatic logic [2:0] ref_sel();
      int a;
      a = int'(addr);
      if (!addr_vld || !ext_dis_n || !pf_rst_n) return 3'b000;
      if (notch_en && a >= 'hB000 && a <= 'hB7FF) return 3'b000;
      case (win_mode)
         2'b00: begin
            if (a <= 'h1FFF) return 3'b001;
            if (a >= 'hC000 && a <= 'hDFFF) return 3'b010;
            if (a >= 'hE000) return 3'b100;
            return 3'b000;
         end
         2'b01: begin
            if (a <= 'h3FFF) return 3'b001;
            if (a >= 'h8000 && a <= 'hBFFF) return 3'b010;
            if (a >= 'hC000) return 3'b100;
            return 3'b000;
         end
         default: begin
            if (a <= 'h7FFF) return 3'b001;
            return 3'b100;
         end
      endcase
   endfunction

   function automatic logic [2:0] ref_we(logic [2:0] sel);
      logic [2:0] w;
      for (int s = 0; s < 3; s++)
         w[s] = sel[s] && bus_e && !rd_wr_n && !wr_prot[s];
      return w;
   endfunction

   task automatic check_now(string tag);
      logic [2:0] es, ew;
      es = ref_sel();
      ew = ref_we(es);
      n_checks++;
      if (sock_cs_n !== ~es) begin
         n_errors++;
         $display("FAIL %s cs_n: addr=%h mode=%b act=%b exp=%b", tag, addr, win_mode, sock_cs_n, ~es);
      end
      n_checks++;
      if (sock_we_n !== ~ew) begin
         n_errors++;
         $display("FAIL %s we_n: addr=%h mode=%b act=%b exp=%b", tag, addr, win_mode, sock_we_n, ~ew);
      end
      n_checks++;
      if ($countones(~sock_cs_n) > 1) begin
         n_errors++;
         $display("FAIL R5 multiple selects: addr=%h act=%b exp=at most one low", addr, sock_cs_n);
      end
   endtask

   // Apply inputs in the E-low phase, check there and again in the E-high phase.
   task automatic apply(input logic [15:0] a, input logic [1:0] m, input logic nt,
                        input logic rw, input logic [2:0] wp, input string tag);
      @(negedge bus_e);
      addr = a; win_mode = m; notch_en = nt; rd_wr_n = rw; wr_prot = wp;
      #1 check_now(tag);
      @(posedge bus_e);
      #1 check_now(tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: act=timeout exp=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      addr = 16'h0000; addr_vld = 1'b1; ext_dis_n = 1'b1; pf_rst_n = 1'b0;
      win_mode = 2'b00; notch_en = 1'b0; rd_wr_n = 1'b0; wr_prot = 3'b000;

      // Reset state: power-fail low keeps everything quiet (R7).
      apply(16'h0000, 2'b00, 1'b0, 1'b0, 3'b000, "R7 reset");
      apply(16'hF000, 2'b10, 1'b0, 1'b0, 3'b000, "R7 reset high");
      pf_rst_n = 1'b1;

      // Strobe and external disable gating (R6).
      addr_vld = 1'b0;
      apply(16'h0000, 2'b00, 1'b0, 1'b0, 3'b000, "R6 strobe low");
      addr_vld = 1'b1; ext_dis_n = 1'b0;
      apply(16'hE000, 2'b00, 1'b0, 1'b0, 3'b000, "R6 disable");
      ext_dis_n = 1'b1;
      apply(16'hE000, 2'b00, 1'b0, 1'b0, 3'b000, "R4 after disable");

      // Notch boundaries in 16K mode (R8).
      apply(16'hAFFF, 2'b01, 1'b1, 1'b1, 3'b000, "R8 below notch");
      apply(16'hB000, 2'b01, 1'b1, 1'b1, 3'b000, "R8 notch start");
      apply(16'hB7FF, 2'b01, 1'b1, 1'b1, 3'b000, "R8 notch end");
      apply(16'hB800, 2'b01, 1'b1, 1'b1, 3'b000, "R8 above notch");
      apply(16'hB000, 2'b01, 1'b0, 1'b1, 3'b000, "R8 notch off");

      // Write strobes and protection (R9, R10).
      apply(16'h0010, 2'b00, 1'b0, 1'b0, 3'b000, "R9 write");
      apply(16'h0010, 2'b00, 1'b0, 1'b1, 3'b000, "R9 read");
      apply(16'h0010, 2'b00, 1'b0, 1'b0, 3'b001, "R10 protect");
      apply(16'hC123, 2'b00, 1'b0, 1'b0, 3'b101, "R10 other protected");

      // Alternate 32K encoding (R11).
      apply(16'h7FFF, 2'b11, 1'b0, 1'b0, 3'b000, "R11 low");
      apply(16'h8000, 2'b11, 1'b0, 1'b0, 3'b000, "R11 high");

      // Sweep every mode with and without notch (R1 R2 R3 R4 R5).
      for (int pass = 0; pass < 8; pass++) begin
         for (int a = 0; a < 65536; a += 16) begin
            @(negedge bus_e);
            addr     = 16'(a);
            win_mode = 2'(pass);
            notch_en = pass[2];
            rd_wr_n  = addr[4];
            wr_prot  = 3'(pass * 3);
            #1 check_now("R1 sweep");
            addr = 16'(a) | 16'h000F;
            #1 check_now("R2/R3/R4 sweep");
            @(posedge bus_e);
            #1 check_now("R5 sweep");
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule